// File: doc/BRIEF.md
# Smart-Card Character Error Handler

This block handles character-level error signalling on a half-duplex smart-card link running the byte-oriented T=0 protocol. On the receive side, a strobe marks each character the receiver has finished. The block then decides whether to ask the line driver for a NACK pulse when that character carried a parity error. Software chooses one of three NACK policies: NACK on every error, no NACK at all, or NACK only for the first few errors in a row. While the cap is in use, a run of bad characters is counted and the count is compared against a 3-bit limit.

On the transmit side, the same 3-bit limit bounds how often a character the card rejected is sent again. When the limit is used up, a sticky flag is raised instead of another retry request. The flag stays up until the next new character starts. A bit-time tick drives a guard counter. After each transmitted character, that counter holds off the next character for 2 to 9 bit times.

Shifting, parity generation and line sampling are done elsewhere. This block only sees strobes and status bits, and returns single-cycle requests and levels.

Top module: `sc_nack_ctrl`

## Requirements
- R1: While reset is asserted, and after reset with no strobes, `nack_req`, `retx_req` and `iter_exceeded` are 0 and `guard_done` is 1.
- R2: With `cfg_no_nack`=0 and `cfg_cap_nack`=0, every `rx_done` with `rx_par_err`=1 gives `nack_req`=1 for exactly the next cycle. An `rx_done` with `rx_par_err`=0 gives no NACK.
- R3: With `cfg_no_nack`=1, `nack_req` stays 0 for every received character, whatever the state of `cfg_cap_nack`.
- R4: With `cfg_cap_nack`=1 and `cfg_no_nack`=0, each parity error raises `nack_req` only while the number of preceding successive errors is below `cfg_max_iter`. If `cfg_max_iter`=0, no NACK is issued at all. The error count saturates at 7.
- R5: A character received without a parity error resets the successive-error count to zero, so the next error is NACKed again.
- R6: A `tx_done` with `tx_nack_seen`=1 gives `retx_req`=1 for exactly the next cycle, provided fewer than `cfg_max_iter` retries have been requested since the last `tx_start`.
- R7: A remote NACK that arrives once the retry count equals `cfg_max_iter` sets `iter_exceeded` and gives no `retx_req`. The flag holds until `tx_start`, which clears the flag and the retry count. When `tx_start` and `tx_done` arrive in the same cycle, `tx_start` takes priority for the retry logic.
- R8: `tx_done` restarts the guard count; a `bit_tick` in that same cycle is ignored. `guard_done` is 0 from the next cycle until `cfg_guard`+2 bit ticks have been counted, and then returns to 1.
- R9: While `t0_en` is 0, `nack_req`, `retx_req` and `iter_exceeded` are 0, both counts are cleared, and `guard_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| t0_en | input | 1 | T=0 character mode enable |
| rx_done | input | 1 | Strobe: one received character finished |
| rx_par_err | input | 1 | Parity error status of that character |
| tx_start | input | 1 | Strobe: a new (not repeated) character begins |
| tx_done | input | 1 | Strobe: a transmitted character's error window closed |
| tx_nack_seen | input | 1 | Card signalled NACK for that character |
| bit_tick | input | 1 | One pulse per elementary bit time |
| cfg_max_iter | input | 3 | Limit on successive NACKs and on retries |
| cfg_cap_nack | input | 1 | 1: cap NACKs at the limit |
| cfg_no_nack | input | 1 | 1: never NACK |
| cfg_guard | input | 3 | Guard time minus two, in bit times |
| nack_req | output | 1 | One-cycle request to drive a NACK |
| retx_req | output | 1 | One-cycle request to repeat the character |
| iter_exceeded | output | 1 | Retry limit exhausted (sticky) |
| guard_done | output | 1 | Guard interval since last character has elapsed |

## Verification
The hardest state to reach from the ports is an exhausted retry budget followed by more rejections, with `tx_start` landing in the same cycle as a `tx_done`. Reaching it takes a long run of remote NACKs with no new character in between. Directed sequences at limits 0 and 2 drive the transmit path through retry, exhaustion, a repeated rejection and the clear. Random traffic then mixes a bench reference model with changing limits and policies, occasional mode drops and coincident strobes.

// File: rtl/sc_nack_pkg.sv
package sc_nack_pkg;
  // Classification of a closed transmit character
  typedef enum logic [1:0] {
    TXEV_NONE    = 2'd0,
    TXEV_ACCEPT  = 2'd1,
    TXEV_RETRY   = 2'd2,
    TXEV_EXHAUST = 2'd3
  } tx_event_e;
endpackage

// File: rtl/sc_rx_nack.sv
module sc_rx_nack #(
  parameter int ITER_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t0_en,
  input  logic              rx_done,
  input  logic              rx_par_err,
  input  logic [ITER_W-1:0] cfg_max_iter,
  input  logic              cfg_cap_nack,
  input  logic              cfg_no_nack,
  output logic              nack_req
);
  localparam logic [ITER_W-1:0] ECNT_SAT = '1;

  logic [ITER_W-1:0] ecnt_q, ecnt_d;
  logic              ecnt_en;
  logic              nack_q, nack_d;

  always_comb begin
    ecnt_d  = ecnt_q;
    nack_d  = 1'b0;
    ecnt_en = !t0_en || rx_done;
    if (!t0_en) begin
      ecnt_d = '0;
    end else if (rx_done) begin
      if (rx_par_err) begin
        nack_d = !cfg_no_nack && (!cfg_cap_nack || (ecnt_q < cfg_max_iter));
        if (ecnt_q != ECNT_SAT) ecnt_d = ecnt_q + 1'b1;
      end else begin
        ecnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q <= '0;
      nack_q <= 1'b0;
    end else begin
      nack_q <= nack_d;
      if (ecnt_en) ecnt_q <= ecnt_d;
    end
  end

  assign nack_req = nack_q;

  assert_plain_nack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    t0_en && rx_done && rx_par_err && !cfg_no_nack && !cfg_cap_nack |=> nack_req);
  assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && cfg_no_nack |=> !nack_req);
  assert_cap_reached_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && cfg_cap_nack && (ecnt_q >= cfg_max_iter) |=> !nack_req);
  assert_good_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    t0_en && rx_done && !rx_par_err |=> (ecnt_q == '0) && !nack_req);
endmodule

// File: rtl/sc_tx_retry.sv
module sc_tx_retry
  import sc_nack_pkg::*;
#(
  parameter int ITER_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t0_en,
  input  logic              tx_start,
  input  logic              tx_done,
  input  logic              tx_nack_seen,
  input  logic [ITER_W-1:0] cfg_max_iter,
  output logic              retx_req,
  output logic              iter_exceeded
);
  tx_event_e         ev;
  logic [ITER_W-1:0] rcnt_q, rcnt_d;
  logic              rcnt_en;
  logic              retx_q, retx_d;
  logic              iexc_q, iexc_d;

  always_comb begin
    ev = TXEV_NONE;
    if (tx_done && !tx_start) begin
      if (!tx_nack_seen)               ev = TXEV_ACCEPT;
      else if (rcnt_q < cfg_max_iter)  ev = TXEV_RETRY;
      else                             ev = TXEV_EXHAUST;
    end
  end

  always_comb begin
    rcnt_d  = rcnt_q;
    iexc_d  = iexc_q;
    retx_d  = 1'b0;
    rcnt_en = 1'b0;
    if (!t0_en || tx_start) begin
      rcnt_d  = '0;
      iexc_d  = 1'b0;
      rcnt_en = 1'b1;
    end else begin
      case (ev)
        TXEV_RETRY: begin
          retx_d  = 1'b1;
          rcnt_d  = rcnt_q + 1'b1;
          rcnt_en = 1'b1;
        end
        TXEV_EXHAUST: iexc_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
      retx_q <= 1'b0;
      iexc_q <= 1'b0;
    end else begin
      retx_q <= retx_d;
      iexc_q <= iexc_d;
      if (rcnt_en) rcnt_q <= rcnt_d;
    end
  end

  assign retx_req      = retx_q;
  assign iter_exceeded = iexc_q;

  assert_retry_issued_R6: assert property (@(posedge clk) disable iff (!rst_n)
    t0_en && !tx_start && tx_done && tx_nack_seen && (rcnt_q < cfg_max_iter) |=> retx_req);
  assert_exhaust_no_retry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    t0_en && !tx_start && tx_done && tx_nack_seen && (rcnt_q >= cfg_max_iter)
      |=> iter_exceeded && !retx_req);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iter_exceeded && t0_en && !tx_start |=> iter_exceeded);
endmodule

// File: rtl/sc_guard_timer.sv
module sc_guard_timer #(
  parameter int GUARD_W   = 3,
  parameter int GUARD_MIN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               t0_en,
  input  logic               tx_done,
  input  logic               bit_tick,
  input  logic [GUARD_W-1:0] cfg_guard,
  output logic               guard_done
);
  localparam int TGT_MAX = (1 << GUARD_W) - 1 + GUARD_MIN;
  localparam int GCNT_W  = $clog2(TGT_MAX + 1);

  logic [GCNT_W-1:0] target;
  logic [GCNT_W-1:0] gcnt_q, gcnt_d;
  logic              gcnt_en;

  assign target = GCNT_W'(cfg_guard) + GCNT_W'(GUARD_MIN);

  always_comb begin
    gcnt_d  = gcnt_q;
    gcnt_en = 1'b0;
    if (!t0_en) begin
      gcnt_d  = '1;
      gcnt_en = 1'b1;
    end else if (tx_done) begin
      gcnt_d  = '0;
      gcnt_en = 1'b1;
    end else if (bit_tick && (gcnt_q < target)) begin
      gcnt_d  = gcnt_q + 1'b1;
      gcnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gcnt_q <= '1;
    else if (gcnt_en) gcnt_q <= gcnt_d;
  end

  assign guard_done = !t0_en || (gcnt_q >= target);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    t0_en && tx_done |=> (!t0_en || !guard_done));
  assert_no_tick_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    t0_en && !guard_done && !bit_tick && $stable(cfg_guard) |=> (!t0_en || !guard_done));
endmodule

// File: rtl/sc_nack_ctrl.sv
module sc_nack_ctrl #(
  parameter int ITER_W    = 3,
  parameter int GUARD_W   = 3,
  parameter int GUARD_MIN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               t0_en,
  input  logic               rx_done,
  input  logic               rx_par_err,
  input  logic               tx_start,
  input  logic               tx_done,
  input  logic               tx_nack_seen,
  input  logic               bit_tick,
  input  logic [ITER_W-1:0]  cfg_max_iter,
  input  logic               cfg_cap_nack,
  input  logic               cfg_no_nack,
  input  logic [GUARD_W-1:0] cfg_guard,
  output logic               nack_req,
  output logic               retx_req,
  output logic               iter_exceeded,
  output logic               guard_done
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  sc_rx_nack #(.ITER_W(ITER_W)) u_rx (
    .clk(clk), .rst_n(core_rst_n), .t0_en(t0_en),
    .rx_done(rx_done), .rx_par_err(rx_par_err),
    .cfg_max_iter(cfg_max_iter), .cfg_cap_nack(cfg_cap_nack),
    .cfg_no_nack(cfg_no_nack), .nack_req(nack_req)
  );

  sc_tx_retry #(.ITER_W(ITER_W)) u_tx (
    .clk(clk), .rst_n(core_rst_n), .t0_en(t0_en),
    .tx_start(tx_start), .tx_done(tx_done), .tx_nack_seen(tx_nack_seen),
    .cfg_max_iter(cfg_max_iter), .retx_req(retx_req),
    .iter_exceeded(iter_exceeded)
  );

  sc_guard_timer #(.GUARD_W(GUARD_W), .GUARD_MIN(GUARD_MIN)) u_guard (
    .clk(clk), .rst_n(core_rst_n), .t0_en(t0_en),
    .tx_done(tx_done), .bit_tick(bit_tick),
    .cfg_guard(cfg_guard), .guard_done(guard_done)
  );

  assert_mode_off_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    !t0_en |=> !nack_req && !retx_req && !iter_exceeded);
  assert_mode_off_guard_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    !t0_en |-> guard_done);
endmodule

// File: tb/sc_nack_ctrl_tb_top.sv
`timescale 1ns/1ps
module sc_nack_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       t0_en, rx_done, rx_par_err, tx_start, tx_done, tx_nack_seen, bit_tick;
  logic [2:0] cfg_max_iter, cfg_guard;
  logic       cfg_cap_nack, cfg_no_nack;
  logic       nack_req, retx_req, iter_exceeded, guard_done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // reference model state
  int m_ecnt, m_rcnt, m_gcnt;
  bit m_nack, m_retx, m_iexc;
  string nack_tag, retx_tag;

  always #4 clk = ~clk;

  sc_nack_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .t0_en(t0_en),
    .rx_done(rx_done), .rx_par_err(rx_par_err),
    .tx_start(tx_start), .tx_done(tx_done), .tx_nack_seen(tx_nack_seen),
    .bit_tick(bit_tick), .cfg_max_iter(cfg_max_iter),
    .cfg_cap_nack(cfg_cap_nack), .cfg_no_nack(cfg_no_nack),
    .cfg_guard(cfg_guard), .nack_req(nack_req), .retx_req(retx_req),
    .iter_exceeded(iter_exceeded), .guard_done(guard_done)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_guard();
    return !t0_en || (m_gcnt >= int'(cfg_guard) + 2);
  endfunction

  function automatic void model_next();
    if (!t0_en) begin
      m_ecnt = 0; m_rcnt = 0; m_iexc = 0; m_nack = 0; m_retx = 0; m_gcnt = 15;
      nack_tag = "R9"; retx_tag = "R9";
      return;
    end
    nack_tag = cfg_no_nack ? "R3" : (cfg_cap_nack ? "R4" : "R2");
    retx_tag = "R6";
    m_nack = 0;
    if (rx_done) begin
      if (rx_par_err) begin
        m_nack = !cfg_no_nack && (!cfg_cap_nack || m_ecnt < int'(cfg_max_iter));
        if (m_ecnt != 7) m_ecnt++;
      end else m_ecnt = 0;
    end
    m_retx = 0;
    if (tx_start) begin
      m_rcnt = 0; m_iexc = 0;
    end else if (tx_done && tx_nack_seen) begin
      if (m_rcnt < int'(cfg_max_iter)) begin m_retx = 1; m_rcnt++; end
      else m_iexc = 1;
    end
    if (tx_done) m_gcnt = 0;
    else if (bit_tick && m_gcnt < int'(cfg_guard) + 2) m_gcnt++;
  endfunction

  task automatic compare_all();
    chk(nack_tag, "nack_req", nack_req, m_nack);
    chk(retx_tag, "retx_req", retx_req, m_retx);
    chk("R7", "iter_exceeded", iter_exceeded, m_iexc);
    chk("R8", "guard_done", guard_done, exp_guard());
  endtask

  task automatic step(input bit t0, input bit rxd, input bit rxe, input bit txs,
                      input bit txd, input bit txn, input bit tk);
    t0_en = t0; rx_done = rxd; rx_par_err = rxe; tx_start = txs;
    tx_done = txd; tx_nack_seen = txn; bit_tick = tk;
    model_next();
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_cfg(input int mi, input bit cap, input bit inh, input int gt);
    cfg_max_iter = 3'(mi); cfg_cap_nack = cap; cfg_no_nack = inh; cfg_guard = 3'(gt);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stimulus
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    set_cfg(0, 0, 0, 0);
    t0_en = 1'b1; rx_done = 0; rx_par_err = 0; tx_start = 0;
    tx_done = 0; tx_nack_seen = 0; bit_tick = 0;
    m_ecnt = 0; m_rcnt = 0; m_gcnt = 15; m_nack = 0; m_retx = 0; m_iexc = 0;
    nack_tag = "R1"; retx_tag = "R1";
    repeat (3) @(negedge clk);
    // R1: reset state with strobes held high
    rx_done = 1; rx_par_err = 1; tx_done = 1; tx_nack_seen = 1;
    @(negedge clk);
    chk("R1", "nack_req in reset", nack_req, 1'b0);
    chk("R1", "retx_req in reset", retx_req, 1'b0);
    chk("R1", "iter_exceeded in reset", iter_exceeded, 1'b0);
    chk("R1", "guard_done in reset", guard_done, 1'b1);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R1", "guard_done idle after reset", guard_done, 1'b1);

    // R2: NACK on every error
    set_cfg(2, 0, 0, 0);
    repeat (4) begin
      step(1, 1, 1, 0, 0, 0, 0);
      chk("R2", "nack after parity error", nack_req, 1'b1);
    end
    step(1, 1, 0, 0, 0, 0, 0);
    chk("R2", "no nack on good char", nack_req, 1'b0);

    // R3: inhibit, also with cap set
    set_cfg(5, 1, 1, 0);
    repeat (3) begin
      step(1, 1, 1, 0, 0, 0, 0);
      chk("R3", "inhibited nack", nack_req, 1'b0);
    end

    // R4 / R5: capped NACKs at limit 2
    set_cfg(2, 1, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0); chk("R4", "first capped error", nack_req, 1'b1);
    step(1, 1, 1, 0, 0, 0, 0); chk("R4", "second capped error", nack_req, 1'b1);
    step(1, 1, 1, 0, 0, 0, 0); chk("R4", "third error suppressed", nack_req, 1'b0);
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0); chk("R5", "nack again after good char", nack_req, 1'b1);
    set_cfg(0, 1, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0); chk("R4", "limit zero gives no nack", nack_req, 1'b0);
    repeat (10) step(1, 1, 1, 0, 0, 0, 0);

    // R6 / R7: retries at limit 2
    set_cfg(2, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 1, 1, 0); chk("R6", "first retry", retx_req, 1'b1);
    step(1, 0, 0, 0, 1, 1, 0); chk("R6", "second retry", retx_req, 1'b1);
    step(1, 0, 0, 0, 1, 1, 0);
    chk("R7", "exhausted: no retry", retx_req, 1'b0);
    chk("R7", "exhausted flag set", iter_exceeded, 1'b1);
    step(1, 0, 0, 0, 1, 0, 0); chk("R7", "flag sticky on accept", iter_exceeded, 1'b1);
    step(1, 0, 0, 1, 1, 1, 0);
    chk("R7", "start clears flag", iter_exceeded, 1'b0);
    chk("R7", "start beats coincident done", retx_req, 1'b0);
    step(1, 0, 0, 0, 1, 1, 0); chk("R7", "count cleared by start", retx_req, 1'b1);
    set_cfg(0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 1, 1, 0); chk("R7", "limit zero exhausts at once", iter_exceeded, 1'b1);

    // R8: guard timing at minimum and maximum
    for (int g = 0; g < 8; g += 7) begin
      set_cfg(3, 0, 0, g);
      step(1, 0, 0, 0, 1, 0, 1);
      chk("R8", "guard low after char, tick ignored", guard_done, 1'b0);
      for (int k = 0; k < g + 2; k++) begin
        step(1, 0, 0, 0, 0, 0, 1);
        chk("R8", "guard vs tick count", guard_done, (k + 1 >= g + 2));
        step(1, 0, 0, 0, 0, 0, 0);
      end
    end

    // R9: mode off
    set_cfg(3, 0, 0, 4);
    step(1, 0, 0, 0, 1, 1, 0);
    repeat (4) begin
      step(0, 1, 1, 0, 1, 1, 0);
      chk("R9", "nack off", nack_req, 1'b0);
      chk("R9", "retx off", retx_req, 1'b0);
      chk("R9", "guard forced done", guard_done, 1'b1);
    end

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if (i % 150 == 0)
        set_cfg($urandom_range(0, 7), $urandom_range(0, 1),
                ($urandom_range(0, 3) == 0), $urandom_range(0, 7));
      step(($urandom_range(0, 39) != 0),
           ($urandom_range(0, 2) == 0), $urandom_range(0, 1),
           ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) != 0),
           ($urandom_range(0, 4) < 2));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule